// File: doc/BRIEF.md
# Prioritised Core Event Controller

This block collects sixteen core event lines, turns each rising edge into a pending latch bit, and offers the most urgent serviceable event to the core. Each event has a mask bit. Software writes this bit to 1 to allow service. A global enable input separately suppresses the general-purpose events (numbers 7 to 15) without touching the mask. The block also tracks which events are active. An event stays active while the core is handling it, or while it sits preempted beneath a more urgent one. This lets nested service be arbitrated correctly.

The block presents one request at a time on a valid/ready pair.

- **Request side.** `req_valid` and `req_id` name the offered event. The core takes it by raising `req_ready` in a cycle where `req_valid` is high.
- **Back-pressure.** The core may hold `req_ready` low for as long as it likes. The request stays up, and carries the same number unless a more urgent event becomes eligible meanwhile.
- **Acceptance.** An accepted request sets that event's active bit and consumes its latch bit.
- **Return.** A one-cycle `ret_valid` pulse with `ret_id` ends service of an event and clears its active bit.

A small register port gives software read/write access to the latch and mask registers and read-only access to the active register.

Top module: `cevt_ctrl`

## Requirements
- R1: After reset the latch, mask and active registers read 0 and `req_valid` is low.
- R2: An event input is sampled by a register; a rising edge seen between the sampled value and the one before it sets the latch bit at the second rising clock edge after the input rises. A level held high sets it only once.
- R3: The mask register sits at register address 1 and reads back as written. An event whose mask bit is 0 is never offered, even when its latch bit is 1.
- R4: A write to register address 0 (latch) changes only the bits whose mask bit is 0. Bits whose mask bit is 1 keep their value.
- R5: Among events whose latch and mask bits are both 1, the lowest-numbered one is offered. It is offered only if its number is below the lowest-numbered set active bit; if no active bit is set, it is offered unconditionally.
- R6: While `gp_enable` is low, events 7 to 15 are not offered. Events 0 to 6 still are, and the mask register keeps its value.
- R7: In a cycle with `req_valid` and `req_ready` both high, the offered event's active bit is set and its latch bit is cleared at the next clock edge. The earliest active assertion comes three clock edges after the input rises. While `req_ready` stays low, `req_valid` and `req_id` hold.
- R8: Several active bits may be set at once. A more urgent event accepted during service of another adds its bit without clearing the other.
- R9: A `ret_valid` pulse clears the active bit numbered by `ret_id` at the next clock edge. Once the active bits below a latched event are cleared, that event is offered again.
- R10: After an event is accepted, a fresh rising edge on its input latches it again. It is not offered while its own active bit is still set.
- R11: The active register at address 2 is read-only; writes to it change nothing. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 16 | Event lines; bit n is event n, bit 0 the most urgent |
| gp_enable | input | 1 | Global enable for events 7 to 15 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 latch, 1 mask, 2 active, 3 reserved |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| req_valid | output | 1 | An event is being offered |
| req_id | output | 4 | Number of the offered event |
| req_ready | input | 1 | Core accepts the offered event |
| ret_valid | input | 1 | Return-from-event strobe |
| ret_id | input | 4 | Number of the event being returned from |

## Verification
The assertions check, on every cycle, the properties of each offer:
- it outranks every active bit;
- it is latched and unmasked;
- it respects the global enable.

They also check the register effects of each handshake and return, that a latch write cannot raise a protected latch bit, and that a write to the active register leaves it unchanged.

Some behaviours are only visible in the bench's scenarios:
- the exact edge-to-latch and edge-to-active cycle counts;
- the single trigger from a held level;
- re-queueing of a fresh edge while the event is still active;
- the order in which nested events come back into view as returns unwind them.

// File: rtl/cevt_pkg.sv
package cevt_pkg;
  typedef enum logic [1:0] {
    RA_LATCH  = 2'd0,
    RA_MASK   = 2'd1,
    RA_ACTIVE = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cevt_edge.sv
module cevt_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] smp_q;
  logic [W-1:0] old_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= '0;
      old_q <= '0;
    end else begin
      smp_q <= lvl_i;
      old_q <= smp_q;
    end
  end

  // a bit is a rising edge when the newest sample is high and the previous one low
  assign rise_o = smp_q & ~old_q;
endmodule

// File: rtl/cevt_first.sv
module cevt_first #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // scan from the top so the lowest set bit wins
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cevt_ctrl.sv
module cevt_ctrl #(
  parameter int N_EVT = 16,
  parameter int GP_LO = 7,
  parameter int IDW   = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             gp_enable,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [N_EVT-1:0] reg_wdata,
  output logic [N_EVT-1:0] reg_rdata,
  output logic             req_valid,
  output logic [IDW-1:0]   req_id,
  input  logic             req_ready,
  input  logic             ret_valid,
  input  logic [IDW-1:0]   ret_id
);
  import cevt_pkg::*;

  localparam logic [N_EVT-1:0] ONE = {{(N_EVT-1){1'b0}}, 1'b1};

  logic [N_EVT-1:0] lat_q, mask_q, act_q;
  logic [N_EVT-1:0] lat_d, mask_d, act_d;
  logic [N_EVT-1:0] rise;
  logic [N_EVT-1:0] gate;
  logic [N_EVT-1:0] cand;
  logic [N_EVT-1:0] take_vec, ret_vec, lat_wr;
  logic             cand_found, act_found;
  logic [IDW-1:0]   cand_idx, act_idx;
  logic             fire;
  reg_addr_e        ra;

  assign ra = reg_addr_e'(reg_addr);

  cevt_edge #(.W(N_EVT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (evt_in),
    .rise_o (rise)
  );

  // general-purpose events follow the global enable, the rest are always gated open
  for (genvar g = 0; g < N_EVT; g++) begin : g_gate
    if (g >= GP_LO) begin : g_gp
      assign gate[g] = gp_enable;
    end else begin : g_core
      assign gate[g] = 1'b1;
    end
  end

  assign cand = lat_q & mask_q & gate;

  cevt_first #(.W(N_EVT), .IW(IDW)) u_cand (
    .vec_i   (cand),
    .found_o (cand_found),
    .idx_o   (cand_idx)
  );

  cevt_first #(.W(N_EVT), .IW(IDW)) u_act (
    .vec_i   (act_q),
    .found_o (act_found),
    .idx_o   (act_idx)
  );

  assign req_valid = cand_found && (!act_found || (cand_idx < act_idx));
  assign req_id    = cand_idx;
  assign fire      = req_valid && req_ready;
  assign take_vec  = fire ? (ONE << cand_idx) : '0;
  assign ret_vec   = ret_valid ? (ONE << ret_id) : '0;

  // software may only rewrite latch bits that are masked off
  always_comb begin
    lat_wr = lat_q;
    if (reg_wr && ra == RA_LATCH) begin
      lat_wr = (lat_q & mask_q) | (reg_wdata & ~mask_q);
    end
    // a fresh edge in the acceptance cycle is kept as a new pending event
    lat_d = (lat_wr & ~take_vec) | rise;
  end

  always_comb begin
    mask_d = mask_q;
    if (reg_wr && ra == RA_MASK) begin
      mask_d = reg_wdata;
    end
  end

  assign act_d = (act_q & ~ret_vec) | take_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= '0;
      act_q  <= '0;
    end else begin
      lat_q  <= lat_d;
      mask_q <= mask_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    unique case (ra)
      RA_LATCH:  reg_rdata = lat_q;
      RA_MASK:   reg_rdata = mask_q;
      RA_ACTIVE: reg_rdata = act_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cevt_ctrl_chk.sv
module cevt_ctrl_chk #(
  parameter int N_EVT = 16,
  parameter int GP_LO = 7,
  parameter int IDW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] lat,
  input logic [N_EVT-1:0] mask,
  input logic [N_EVT-1:0] act,
  input logic [N_EVT-1:0] rise,
  input logic             gp_enable,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             req_valid,
  input logic [IDW-1:0]   req_id,
  input logic             req_ready,
  input logic             ret_valid,
  input logic [IDW-1:0]   ret_id
);
  logic [N_EVT-1:0] upto;
  always_comb begin
    for (int i = 0; i < N_EVT; i++) upto[i] = (i <= int'(req_id));
  end

  AST_OFFER_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((act & upto) == '0)); // R5
  AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lat[req_id] && mask[req_id])); // R3
  AST_GP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !gp_enable) |-> (int'(req_id) < GP_LO)); // R6
  AST_ACCEPT_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> act[$past(req_id)]); // R7
  AST_ACCEPT_CLEARS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rise[req_id]) |=> !lat[$past(req_id)]); // R7
  AST_NEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ret_valid) |=> ((act & $past(act)) == $past(act))); // R8
  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !(req_valid && req_ready && req_id == ret_id)) |=> !act[$past(ret_id)]); // R9
  AST_LATCH_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> ((lat & ~$past(lat) & $past(mask) & ~$past(rise)) == '0)); // R4
  AST_ACT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !req_ready && !ret_valid) |=> $stable(act)); // R11
endmodule

bind cevt_ctrl cevt_ctrl_chk #(.N_EVT(N_EVT), .GP_LO(GP_LO), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lat       (lat_q),
  .mask      (mask_q),
  .act       (act_q),
  .rise      (rise),
  .gp_enable (gp_enable),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .req_valid (req_valid),
  .req_id    (req_id),
  .req_ready (req_ready),
  .ret_valid (ret_valid),
  .ret_id    (ret_id)
);

// File: tb/cevt_ctrl_tb.sv
`timescale 1ns/1ps
module cevt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        gp_enable = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid;
  logic [3:0]  req_id;
  logic        req_ready = 1'b0;
  logic        ret_valid = 1'b0;
  logic [3:0]  ret_id = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cevt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .gp_enable(gp_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .ret_valid(ret_valid), .ret_id(ret_id)
  );

  // vector: {latch, mask, gp_enable, exp_valid, exp_id}
  localparam int NV = 7;
  localparam logic [37:0] VEC [NV] = '{
    {16'h0000, 16'hFFFF, 1'b1, 1'b0, 4'd0},
    {16'h8100, 16'hFFFF, 1'b1, 1'b1, 4'd8},
    {16'h8100, 16'h8000, 1'b1, 1'b1, 4'd15},
    {16'h8180, 16'hFFFF, 1'b0, 1'b0, 4'd0},
    {16'h8140, 16'hFFFF, 1'b0, 1'b1, 4'd6},
    {16'h0005, 16'h0004, 1'b1, 1'b1, 4'd2},
    {16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 latch", d, 0);
    rd(2'd1, d); check("R1 mask", d, 0);
    rd(2'd2, d); check("R1 active", d, 0);
    check("R1 req_valid", req_valid, 0);

    // table: priority, masking, global enable
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      wr(2'd1, 16'h0000);
      wr(2'd0, v[37:22]);
      wr(2'd1, v[21:6]);
      gp_enable = v[5];
      #0.1;
      check($sformatf("R5/R6 vec%0d valid", i), req_valid, v[4]);
      if (v[4]) check($sformatf("R5/R6 vec%0d id", i), req_id, v[3:0]);
    end
    rd(2'd1, d); check("R3 mask readback", d, 16'h0000);
    gp_enable = 1'b1;
    wr(2'd0, 16'h0000);

    // R4 latch write protection
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R4 protected latch", d, 16'hFFFB);
    check("R3 masked-in but unlatched not offered", req_valid, 0);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0000);

    // R2 edge latency, R7 accept and three-edge latency
    wr(2'd1, 16'h0024);
    evt_in[5] = 1'b1;
    tick();
    rd(2'd0, d); check("R2 latch after one edge", d, 16'h0000);
    tick();
    rd(2'd0, d); check("R2 latch after two edges", d, 16'h0020);
    check("R7 offered valid", req_valid, 1);
    check("R7 offered id", req_id, 5);
    // back-pressure
    tick(); tick();
    check("R7 held valid", req_valid, 1);
    check("R7 held id", req_id, 5);
    rd(2'd2, d); check("R7 no accept without ready", d, 16'h0000);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    rd(2'd2, d); check("R7 active set", d, 16'h0020);
    rd(2'd0, d); check("R7 latch cleared", d, 16'h0000);

    // R2 held level does not retrigger
    tick(); tick(); tick();
    rd(2'd0, d); check("R2 level no retrigger", d, 16'h0000);

    // R10 re-queue while active
    evt_in[5] = 1'b0;
    tick(); tick();
    evt_in[5] = 1'b1;
    tick(); tick();
    rd(2'd0, d); check("R10 requeued latch", d, 16'h0020);
    check("R10 not offered under own active", req_valid, 0);

    // R8 nesting
    evt_in[2] = 1'b1;
    tick(); tick();
    check("R8 urgent offered valid", req_valid, 1);
    check("R8 urgent offered id", req_id, 2);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    rd(2'd2, d); check("R8 two active", d, 16'h0024);

    // R11 active read-only, reserved reads zero
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); check("R11 active unchanged", d, 16'h0024);
    rd(2'd3, d); check("R11 reserved zero", d, 16'h0000);

    // R9 return unwinds
    ret_valid = 1'b1; ret_id = 4'd2;
    tick();
    ret_valid = 1'b0;
    rd(2'd2, d); check("R9 inner returned", d, 16'h0020);
    check("R9 still blocked by own active", req_valid, 0);
    ret_valid = 1'b1; ret_id = 4'd5;
    tick();
    ret_valid = 1'b0;
    rd(2'd2, d); check("R9 outer returned", d, 16'h0000);
    check("R9 requeued offered valid", req_valid, 1);
    check("R9 requeued offered id", req_id, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule